// File: doc/BRIEF.md
# Block Compare Search Sequencer

This block carries out a byte search through memory. A start pulse loads a 16-bit pointer, a 16-bit count, an 8-bit search value (the accumulator) and the incoming carry flag, together with a second opcode byte that selects the search direction and whether the search repeats. Each iteration reads the byte at the pointer through a synchronous read port and compares it with the accumulator as a subtraction that only produces flags. It then steps the pointer and decrements the count. A single-step operation runs one iteration. A repeating operation keeps going while the count is nonzero and no match has been found.

The sequencer also keeps a running total of modelled clock states for the operation. An iteration that leads to another iteration costs 21 states, and the last one costs 16. Between iterations of a repeating search, an interrupt request input is sampled. When it is high, the search stops with the pointer and count already stepped and raises a resume-needed flag, so software can issue the operation again.

The state machine has four states. IDLE waits for a start with a valid code (transition "launch"). FETCH drives the read port for one cycle ("read") and goes on to COMPARE. COMPARE takes the read byte, updates pointer, count and flags, and then takes one of three transitions: back to FETCH ("iterate"), to FINISH because the search ended ("terminate"), or to FINISH because an interrupt was accepted ("yield"). FINISH pulses done and returns to IDLE ("retire").

Top module: `blk_cmp_search`

## Requirements
- R1: After reset, ptr_out, cnt_out, flags and tstates are zero, and busy, done, mem_rd_en and resume_req are low.
- R2: A start is accepted only in IDLE and only with op_sel equal to 8'hA1 (forward, single), 8'hA9 (backward, single), 8'hB1 (forward, repeat) or 8'hB9 (backward, repeat). Bit 3 selects backward and bit 4 selects repeat. Any other code, or a start while busy, has no effect on the outputs.
- R3: The flags byte has S at bit 7, Z at bit 6, H at bit 4, P/V at bit 2, N at bit 1 and C at bit 0, with bits 5 and 3 zero. S, Z and H come from acc minus the read byte, where H is a borrow out of the low nibble. N is 1. C keeps the carry_in value loaded at start.
- R4: Each iteration moves the pointer by +1 in forward mode or by -1 in backward mode, modulo 2^16.
- R5: Each iteration decrements the count by 1. P/V is 1 when the count after the step is nonzero and 0 when it is zero.
- R6: A repeat operation starts another iteration only while the count after the step is nonzero and Z is 0. A single operation runs exactly one iteration.
- R7: tstates equals the sum over the operation's iterations of 21 for each iteration that continues (or is stopped by an interrupt) and 16 for the iteration that terminates. A single operation gives 16.
- R8: If irq is high when a repeat iteration would continue, the operation ends with the stepped pointer and count and with resume_req set to 1. resume_req is cleared by the next accepted start.
- R9: A count of 0 at start acts as 65536. It does not end the operation, and the first step gives 16'hFFFF with P/V set.
- R10: Each iteration drives mem_rd_en for exactly one cycle, with mem_addr equal to the current pointer. The byte is taken on the cycle after that. An operation of n iterations raises done 2n+1 cycles after the start is sampled.
- R11: done is a one-cycle pulse at the end of each operation. busy is high from the cycle after an accepted start until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| op_sel | input | 8 | Second opcode byte selecting direction and repeat |
| acc | input | 8 | Search value (accumulator) |
| ptr_in | input | 16 | Starting pointer |
| cnt_in | input | 16 | Starting count, 0 means 65536 |
| carry_in | input | 1 | Carry flag carried through unchanged |
| irq | input | 1 | Interrupt request, sampled between iterations |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | End-of-operation pulse |
| ptr_out | output | 16 | Updated pointer |
| cnt_out | output | 16 | Updated count |
| flags | output | 8 | Flag byte |
| resume_req | output | 1 | Operation stopped by an interrupt |
| tstates | output | 24 | Modelled clock states of the operation |

## Verification
On every cycle, the assertions check the one-cycle shape of done and of the read strobe, that no read occurs outside an operation, and that the pointer moves by exactly one step between successive reads. They also check that carry stays fixed during a run, that P/V and N are consistent at done, and that a repeat which ends without an interrupt ends on a zero count or a match. Only the bench scenarios can show the actual flag values for chosen bytes, the timing totals, the total latency of a run, the wrap of the pointer and the count, the effect of the interrupt, and that bad codes and starts during a run are ignored.

// File: rtl/csrch_pkg.sv
package csrch_pkg;

    localparam int FLG_S  = 7;
    localparam int FLG_Z  = 6;
    localparam int FLG_H  = 4;
    localparam int FLG_PV = 2;
    localparam int FLG_N  = 1;
    localparam int FLG_C  = 0;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_COMPARE = 2'd2,
        ST_FINISH  = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic valid;
        logic backward;
        logic repeat_en;
    } op_mode_t;

    // Accepted codes are 101x_x001; bit 3 is direction, bit 4 is repeat.
    function automatic op_mode_t decode_op(input logic [7:0] code);
        op_mode_t m;
        m.valid     = (code[7:5] == 3'b101) && (code[2:0] == 3'b001);
        m.backward  = code[3];
        m.repeat_en = code[4];
        return m;
    endfunction

endpackage

// File: rtl/csrch_flag_unit.sv
module csrch_flag_unit #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] mbyte,
    input  logic              count_nz,
    input  logic              carry_keep,
    output logic [7:0]        flags_new,
    output logic              match
);
    import csrch_pkg::*;

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] diff;
    logic              half_borrow;

    always_comb begin
        diff        = acc - mbyte;
        half_borrow = (acc[HALF_W-1:0] < mbyte[HALF_W-1:0]);
        match       = (diff == '0);
        flags_new           = '0;
        flags_new[FLG_S]    = diff[DATA_W-1];
        flags_new[FLG_Z]    = match;
        flags_new[FLG_H]    = half_borrow;
        flags_new[FLG_PV]   = count_nz;
        flags_new[FLG_N]    = 1'b1;
        flags_new[FLG_C]    = carry_keep;
    end

endmodule

// File: rtl/csrch_step_unit.sv
module csrch_step_unit #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic [ADDR_W-1:0] ptr_cur,
    input  logic [CNT_W-1:0]  cnt_cur,
    input  logic              backward,
    output logic [ADDR_W-1:0] ptr_next,
    output logic [CNT_W-1:0]  cnt_next,
    output logic              cnt_next_nz
);
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);

    always_comb begin
        ptr_next    = backward ? (ptr_cur - ONE_A) : (ptr_cur + ONE_A);
        cnt_next    = cnt_cur - ONE_C;
        cnt_next_nz = (cnt_next != '0);
    end

endmodule

// File: rtl/csrch_tstate_acc.sv
module csrch_tstate_acc #(
    parameter int TS_W     = 24,
    parameter int T_REPEAT = 21,
    parameter int T_FINAL  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            add_en,
    input  logic            add_long,
    output logic [TS_W-1:0] total
);
    localparam logic [TS_W-1:0] INC_LONG  = TS_W'(T_REPEAT);
    localparam logic [TS_W-1:0] INC_SHORT = TS_W'(T_FINAL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total <= '0;
        end else if (clear) begin
            total <= '0;
        end else if (add_en) begin
            total <= total + (add_long ? INC_LONG : INC_SHORT);
        end
    end

endmodule

// File: rtl/blk_cmp_search.sv
module blk_cmp_search #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 16,
    parameter int TS_W     = 24,
    parameter int T_REPEAT = 21,
    parameter int T_FINAL  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        op_sel,
    input  logic [DATA_W-1:0] acc,
    input  logic [ADDR_W-1:0] ptr_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              carry_in,
    input  logic              irq,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] ptr_out,
    output logic [CNT_W-1:0]  cnt_out,
    output logic [7:0]        flags,
    output logic              resume_req,
    output logic [TS_W-1:0]   tstates
);
    import csrch_pkg::*;

    seq_state_t state_q, state_d;
    op_mode_t   mode_in;

    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] acc_q;
    logic [7:0]        flag_q;
    logic              back_q;
    logic              rep_q;
    logic              resume_q;

    logic [ADDR_W-1:0] ptr_nx;
    logic [CNT_W-1:0]  cnt_nx;
    logic              cnt_nx_nz;
    logic [7:0]        flag_nx;
    logic              hit;
    logic              launch;
    logic              more;
    logic              in_compare;

    assign mode_in    = decode_op(op_sel);
    assign launch     = (state_q == ST_IDLE) && start && mode_in.valid;
    assign in_compare = (state_q == ST_COMPARE);
    assign more       = rep_q && cnt_nx_nz && !hit;

    csrch_step_unit #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_step (
        .ptr_cur     (ptr_q),
        .cnt_cur     (cnt_q),
        .backward    (back_q),
        .ptr_next    (ptr_nx),
        .cnt_next    (cnt_nx),
        .cnt_next_nz (cnt_nx_nz)
    );

    csrch_flag_unit #(
        .DATA_W (DATA_W)
    ) u_flag (
        .acc        (acc_q),
        .mbyte      (mem_rdata),
        .count_nz   (cnt_nx_nz),
        .carry_keep (flag_q[FLG_C]),
        .flags_new  (flag_nx),
        .match      (hit)
    );

    csrch_tstate_acc #(
        .TS_W     (TS_W),
        .T_REPEAT (T_REPEAT),
        .T_FINAL  (T_FINAL)
    ) u_tacc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (launch),
        .add_en   (in_compare),
        .add_long (more),
        .total    (tstates)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (launch) state_d = ST_FETCH;
            ST_FETCH:   state_d = ST_COMPARE;
            ST_COMPARE: state_d = (more && !irq) ? ST_FETCH : ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers driven by the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            cnt_q    <= '0;
            acc_q    <= '0;
            flag_q   <= '0;
            back_q   <= 1'b0;
            rep_q    <= 1'b0;
            resume_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        ptr_q         <= ptr_in;
                        cnt_q         <= cnt_in;
                        acc_q         <= acc;
                        flag_q[FLG_C] <= carry_in;
                        back_q        <= mode_in.backward;
                        rep_q         <= mode_in.repeat_en;
                        resume_q      <= 1'b0;
                    end
                end
                ST_COMPARE: begin
                    ptr_q  <= ptr_nx;
                    cnt_q  <= cnt_nx;
                    flag_q <= flag_nx;
                    if (more && irq) resume_q <= 1'b1;
                end
                ST_FETCH, ST_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    // port outputs
    always_comb begin
        mem_rd_en  = (state_q == ST_FETCH);
        mem_addr   = ptr_q;
        busy       = (state_q == ST_FETCH) || (state_q == ST_COMPARE);
        done       = (state_q == ST_FINISH);
        ptr_out    = ptr_q;
        cnt_out    = cnt_q;
        flags      = flag_q;
        resume_req = resume_q;
    end

endmodule

// File: rtl/csrch_chk.sv
module csrch_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              done,
    input logic [CNT_W-1:0]  cnt_out,
    input logic [7:0]        flags,
    input logic              resume_req,
    input logic              back_q,
    input logic              rep_q
);
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en); // R10

    AST_NO_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_en); // R10

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en, 2)) |->
            (mem_addr == (back_q ? $past(mem_addr, 2) - ONE_A
                                 : $past(mem_addr, 2) + ONE_A))); // R4

    AST_CARRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (flags[0] == $past(flags[0]))); // R3

    AST_N_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags[1] && !flags[5] && !flags[3])); // R3

    AST_PV_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags[2] == (cnt_out != '0))); // R5

    AST_REPEAT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rep_q && !resume_req) |-> ((cnt_out == '0) || flags[6])); // R6

    AST_RESUME_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && resume_req) |-> (rep_q && !flags[6] && (cnt_out != '0))); // R8

endmodule

bind blk_cmp_search csrch_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) i_csrch_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .busy       (busy),
    .done       (done),
    .cnt_out    (cnt_out),
    .flags      (flags),
    .resume_req (resume_req),
    .back_q     (back_q),
    .rep_q      (rep_q)
);

// File: tb/test_blk_cmp_search.sv
module test_blk_cmp_search;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  op_sel = 8'h00;
    logic [7:0]  acc = 8'h00;
    logic [15:0] ptr_in = 16'h0000;
    logic [15:0] cnt_in = 16'h0000;
    logic        carry_in = 1'b0;
    logic        irq = 1'b0;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic        busy;
    logic        done;
    logic [15:0] ptr_out;
    logic [15:0] cnt_out;
    logic [7:0]  flags;
    logic        resume_req;
    logic [23:0] tstates;
    logic [7:0]  seed = 8'h00;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory: byte at address a is a[7:0] + seed
    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem_addr[7:0] + seed;
    end

    blk_cmp_search i_blk_cmp_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_sel     (op_sel),
        .acc        (acc),
        .ptr_in     (ptr_in),
        .cnt_in     (cnt_in),
        .carry_in   (carry_in),
        .irq        (irq),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .done       (done),
        .ptr_out    (ptr_out),
        .cnt_out    (cnt_out),
        .flags      (flags),
        .resume_req (resume_req),
        .tstates    (tstates)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    // Launch one operation, predict it from the requirements, compare.
    task automatic run_op(input string tag, input logic [7:0] op, input logic [15:0] p0,
                          input logic [15:0] c0, input logic [7:0] a, input logic cy,
                          input logic irq_lvl, input logic poke_busy);
        logic [15:0] p = p0;
        logic [15:0] c = c0;
        logic [7:0]  b, d;
        logic        s, z, h, pv, more, res;
        int          iters = 0;
        int          ts = 0;
        int          cyc;
        logic        back = op[3];
        logic        rep  = op[4];
        res = 1'b0; s = 0; z = 0; h = 0; pv = 0;
        for (int k = 0; k < 1000; k++) begin
            b  = p[7:0] + seed;
            d  = a - b;
            s  = d[7];
            z  = (d == 8'h00);
            h  = (a[3:0] < b[3:0]);
            p  = back ? p - 16'd1 : p + 16'd1;
            c  = c - 16'd1;
            pv = (c != 16'd0);
            iters++;
            more = rep && pv && !z;
            ts += more ? 21 : 16;
            if (!more) break;
            if (irq_lvl) begin res = 1'b1; break; end
        end
        @(negedge clk);
        op_sel = op; ptr_in = p0; cnt_in = c0; acc = a; carry_in = cy; irq = irq_lvl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        chk({tag, " R11 busy after start"}, busy, 1);
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (poke_busy && cyc == 2) begin
                op_sel = 8'hA9; ptr_in = 16'hDEAD; cnt_in = 16'd1; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk({tag, " R10 latency"}, cyc, 2 * iters + 1);
        chk({tag, " R4 pointer"}, ptr_out, p);
        chk({tag, " R5 count"}, cnt_out, c);
        chk({tag, " R3 flags"}, flags, {s, z, 1'b0, h, 1'b0, pv, 1'b1, cy});
        chk({tag, " R7 tstates"}, tstates, ts);
        chk({tag, " R8 resume"}, resume_req, res);
        @(negedge clk);
        chk({tag, " R11 done pulse"}, done, 0);
        irq = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 ptr", ptr_out, 0);
        chk("R1 cnt", cnt_out, 0);
        chk("R1 flags", flags, 0);
        chk("R1 tstates", tstates, 0);
        chk("R1 ctrl", {busy, done, mem_rd_en, resume_req}, 0);
    endtask

    task automatic t_single_fwd;   // R3 R4 R5 R7
        seed = 8'h20;
        run_op("single_fwd", 8'hA1, 16'h2000, 16'd3, 8'h10, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_single_bwd_wrap;   // R4 wrap, R5 P/V clear, match
        seed = 8'h33;
        run_op("single_bwd_wrap", 8'hA9, 16'h0000, 16'd1, 8'h33, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_half_borrow;   // R3 H
        seed = 8'h0F;
        run_op("half_borrow", 8'hA1, 16'h5000, 16'd9, 8'h31, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_rep_fwd_match;   // R6 R7
        seed = 8'h00;
        run_op("rep_fwd_match", 8'hB1, 16'h3010, 16'd10, 8'h14, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_rep_bwd_match;   // R6 R4
        seed = 8'h00;
        run_op("rep_bwd_match", 8'hB9, 16'h4050, 16'd20, 8'h4C, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_rep_exhaust;   // R6 R5
        seed = 8'h00;
        run_op("rep_exhaust", 8'hB1, 16'h1000, 16'd5, 8'h80, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_irq_zero_count;   // R8 R9
        seed = 8'h00;
        run_op("irq_zero_count", 8'hB1, 16'h6000, 16'd0, 8'hF0, 1'b1, 1'b1, 1'b0);
        chk("R9 zero count step", cnt_out, 16'hFFFF);
        chk("R8 resume set", resume_req, 1);
        seed = 8'h00;
        run_op("resume_cleared", 8'hA1, 16'h6001, 16'hFFFF, 8'h01, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_single_zero_count;   // R9
        seed = 8'h00;
        run_op("single_zero_count", 8'hA9, 16'h7000, 16'd0, 8'h55, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_bad_code;   // R2
        logic [15:0] p_keep = ptr_out;
        logic [23:0] t_keep = tstates;
        @(negedge clk);
        op_sel = 8'hA0; ptr_in = 16'hBEEF; cnt_in = 16'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 bad code busy", busy, 0);
        repeat (4) @(negedge clk);
        chk("R2 bad code done", done, 0);
        chk("R2 bad code ptr", ptr_out, p_keep);
        chk("R2 bad code tstates", tstates, t_keep);
    endtask

    task automatic t_start_while_busy;   // R2
        seed = 8'h00;
        run_op("start_while_busy R2", 8'hB1, 16'h0800, 16'd4, 8'hFF, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single_fwd();
        t_single_bwd_wrap();
        t_half_borrow();
        t_rep_fwd_match();
        t_rep_bwd_match();
        t_rep_exhaust();
        t_irq_zero_count();
        t_single_zero_count();
        t_bad_code();
        t_start_while_busy();
        report();
        $finish;
    end

endmodule